// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walk Engine

This block runs the table-driven DMA of an SD host controller. Once started, it reads a chain of descriptors from system memory, starting at a programmed pointer. The descriptors come in one of three little-endian layouts: a one-word 32-bit form, a two-word 32-bit form and a three-word 64-bit form. Each descriptor is decoded into a target address, a byte length and an attribute. The attribute either moves data, loads a length, links to another table or does nothing.

Transfer descriptors stream 32-bit words between memory and the card-side data port. The engine marks the word that completes each card block, and the block position carries on across descriptors. Any failed memory access ends the walk and leaves the descriptor pointer on the descriptor that failed. The error then shows in the status outputs, but only when the error status enable allows it. A descriptor carrying the end flag finishes the walk and raises transfer complete.

The host logic sets the mode, direction, block size, block count and error enable. It then pulses `start` and watches `busy`, the status outputs and `irq`.

Top module: `adma_engine`

## Requirements
- R1: After reset, `busy`, `mem_req`, `xfer_cmpl`, `adma_err`, `err_summary` and `irq` are all 0.
- R2: When `dma_mode`=2'b10 (32-bit two-word form), the engine fetches word 0 at the pointer and word 1 at pointer+4. In word 0, bit 0 is valid, bit 1 is end, bits 5:4 are the action (00 no-op, 10 transfer, 11 link, 01 no-op) and bits 31:16 are the length. Word 1 is the address, and the pointer then advances by 8.
- R3: When `dma_mode`=2'b01 (one-word form), each descriptor is one word with its attribute in bits 6:0 (same bit meanings as R2) and its address in bits 31:12 over 12 zero bits. Action 01 loads bits 31:16 as the length for later transfers; this length is cleared when a walk begins. The pointer advances by 4.
- R4: When `dma_mode`=2'b11 (64-bit form), word 0 holds the attribute byte (bits 7:0, of which bits 7:6 have no effect) and the length (bits 31:16). Words 1 and 2 hold the low and high halves of the address, and the pointer advances by 12.
- R5: A link descriptor loads the pointer with its address field instead of advancing it.
- R6: A transfer length of zero moves 65536 bytes. Lengths are multiples of 4 bytes, and words go to consecutive addresses from the descriptor address.
- R7: With `dir_to_mem`=1, each transfer word is popped from `card_rd_data` and written to memory. With `dir_to_mem`=0, each word read from memory is presented on `card_wr_data` with `card_wr_valid`.
- R8: `card_blk_end` marks the word that completes a block of the effective size (`blk_size` & 0xFFF, a multiple of 4). The count carries across descriptors and restarts with each walk. When the effective size is zero, it never asserts.
- R9: A memory error on a descriptor fetch or on a data word ends the walk. The pointer stays at the failing descriptor, and the card sees no word for the failed access.
- R10: On any walk error, `adma_err` and `err_summary` are set only if `adma_err_en` is 1. `irq` is `err_summary` OR `xfer_cmpl`.
- R11: A descriptor with its valid bit clear ends the walk as an error (R10), leaving the pointer on that descriptor.
- R12: After a descriptor with the end bit set, the pointer advances (or links), `xfer_cmpl` is set and `busy` falls.
- R13: `start` is ignored while `blk_cnt_en`=1 and `blk_cnt`=0, and also while `dma_mode`=2'b00. In either case no memory request is made and no state changes.
- R14: While `mem_req` is high and `mem_ack` is low, the request and its address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a table walk |
| dma_mode | input | 2 | Descriptor layout select |
| desc_base | input | 64 | First descriptor address |
| blk_size | input | 16 | Block size register (low 12 bits used) |
| blk_cnt | input | 16 | Block count register |
| blk_cnt_en | input | 1 | Block count enable |
| dir_to_mem | input | 1 | 1: card to memory, 0: memory to card |
| adma_err_en | input | 1 | Error status enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 64 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_err | input | 1 | Access failed (with ack) |
| card_rd_data | input | 32 | Next word from the card |
| card_rd_pop | output | 1 | Card word consumed |
| card_wr_valid | output | 1 | Word to card valid |
| card_wr_data | output | 32 | Word to card |
| card_blk_end | output | 1 | This word completes a block |
| busy | output | 1 | Walk in progress |
| desc_ptr | output | 64 | Current descriptor pointer |
| xfer_cmpl | output | 1 | Transfer complete status |
| adma_err | output | 1 | Descriptor DMA error status |
| err_summary | output | 1 | Error summary status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a memory error in the middle of a transfer, after the descriptor fetch has already succeeded. The error must leave the pointer unchanged and mark nothing for the card. The bench reaches it by loading a table whose data region contains one poisoned word address: the memory model answers that address with an error. It runs this case once with the error enable set and once with it clear. A fetch-side error uses the same mechanism on the second word of a 64-bit descriptor. In both cases, the per-access reference queue checks that the walk stops exactly at the poisoned access.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 17;
  localparam int NWORDS = 3;

  typedef enum logic [1:0] {
    DMA_NONE  = 2'b00,
    DMA_A1    = 2'b01,
    DMA_A2_32 = 2'b10,
    DMA_A2_64 = 2'b11
  } dma_mode_e;

  typedef enum logic [1:0] {
    ACT_NOP  = 2'b00,
    ACT_SET  = 2'b01,
    ACT_XFER = 2'b10,
    ACT_LINK = 2'b11
  } act_e;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_DATA} walk_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [15:0]       len;
    logic              valid;
    logic              last;
    act_e              act;
  } desc_t;

  // index of the final word of a descriptor in each layout
  function automatic logic [1:0] last_word(dma_mode_e m);
    case (m)
      DMA_A2_32: return 2'd1;
      DMA_A2_64: return 2'd2;
      default:   return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/adma_desc_decode.sv
module adma_desc_decode
  import adma_pkg::*;
(
  input  dma_mode_e         mode,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  output desc_t             dsc
);
  // attribute bits with no effect in any layout
  logic unused_attr;
  assign unused_attr = ^{w0[11:6], w0[3:2]};

  always_comb begin
    dsc.valid = w0[0];
    dsc.last  = w0[1];
    dsc.act   = act_e'(w0[5:4]);
    dsc.len   = w0[31:16];
    case (mode)
      DMA_A1:    dsc.addr = {{(ADDR_W-32){1'b0}}, w0[31:12], 12'h000};
      DMA_A2_64: dsc.addr = {w2, w1};
      default:   dsc.addr = {{(ADDR_W-32){1'b0}}, w1};
    endcase
  end
endmodule

// File: rtl/adma_blk_track.sv
module adma_blk_track #(
  parameter int MASK_W = 12,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              beat,
  input  logic [MASK_W-1:0] eff_size,
  output logic              last
);
  logic [MASK_W:0] pos_q, pos_d, pos_nxt;

  assign pos_nxt = pos_q + (MASK_W+1)'(STEP);
  assign last    = beat && (eff_size != '0) && (pos_nxt >= {1'b0, eff_size});

  always_comb begin
    pos_d = pos_q;
    if (clr)       pos_d = '0;
    else if (beat) pos_d = last ? '0 : pos_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int BSZ_W  = 16,
  parameter int CNT_W  = 16,
  parameter int MASK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        dma_mode,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [BSZ_W-1:0]  blk_size,
  input  logic [CNT_W-1:0]  blk_cnt,
  input  logic              blk_cnt_en,
  input  logic              dir_to_mem,
  input  logic              adma_err_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] card_rd_data,
  output logic              card_rd_pop,
  output logic              card_wr_valid,
  output logic [WORD_W-1:0] card_wr_data,
  output logic              card_blk_end,
  output logic              busy,
  output logic [ADDR_W-1:0] desc_ptr,
  output logic              xfer_cmpl,
  output logic              adma_err,
  output logic              err_summary,
  output logic              irq
);
  localparam int STEP = WORD_W / 8;

  walk_st_e          st_q, st_d;
  dma_mode_e         mode_q, mode_d;
  logic              dir_q, dir_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, xaddr_q, xaddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d, xlen;
  logic [15:0]       len1_q, len1_d, len_sel;
  logic [1:0]        widx_q, widx_d;
  logic              cmpl_q, cmpl_d, aerr_q, aerr_d, esum_q, esum_d;
  logic              start_ok, walk_clr, beat_ok, finish, fail;
  logic [WORD_W-1:0] wbuf [NWORDS];
  logic [3:0]        stride;
  desc_t             dsc;

  logic bsz_unused;
  assign bsz_unused = ^blk_size[BSZ_W-1:MASK_W];

  // descriptor word capture, one register per word slot
  for (genvar g = 0; g < NWORDS; g++) begin : g_wbuf
    logic cap_en;
    assign cap_en = (st_q == S_FETCH) && mem_ack && !mem_err && (widx_q == 2'(g));
    always_ff @(posedge clk) begin
      if (cap_en) wbuf[g] <= mem_rdata;
    end
  end

  adma_desc_decode u_dec (
    .mode (mode_q),
    .w0   (wbuf[0]),
    .w1   (wbuf[1]),
    .w2   (wbuf[2]),
    .dsc  (dsc)
  );

  adma_blk_track #(.MASK_W(MASK_W), .STEP(STEP)) u_blk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (walk_clr),
    .beat     (beat_ok),
    .eff_size (blk_size[MASK_W-1:0]),
    .last     (card_blk_end)
  );

  assign stride   = {last_word(mode_q), 2'b00} + 4'(STEP);
  assign len_sel  = (mode_q == DMA_A1) ? len1_q : dsc.len;
  assign xlen     = {(len_sel == 16'h0), len_sel};
  assign start_ok = start && (dma_mode_e'(dma_mode) != DMA_NONE) &&
                    !(blk_cnt_en && (blk_cnt == '0));

  always_comb begin
    st_d = st_q;  mode_d = mode_q;  dir_d = dir_q;
    ptr_d = ptr_q;  xaddr_d = xaddr_q;  rem_d = rem_q;
    len1_d = len1_q;  widx_d = widx_q;
    cmpl_d = cmpl_q;  aerr_d = aerr_q;  esum_d = esum_q;
    walk_clr = 1'b0;  beat_ok = 1'b0;  finish = 1'b0;  fail = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;
    mem_addr = ptr_q + {{(ADDR_W-4){1'b0}}, widx_q, 2'b00};
    unique case (st_q)
      S_IDLE: if (start_ok) begin
        st_d = S_FETCH;  mode_d = dma_mode_e'(dma_mode);  dir_d = dir_to_mem;
        ptr_d = desc_base;  widx_d = '0;  len1_d = '0;
        cmpl_d = 1'b0;  aerr_d = 1'b0;  esum_d = 1'b0;  walk_clr = 1'b1;
      end
      S_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_err)                          fail   = 1'b1;
          else if (widx_q == last_word(mode_q)) st_d   = S_EXEC;
          else                                  widx_d = widx_q + 2'd1;
        end
      end
      S_EXEC: begin
        if (!dsc.valid) fail = 1'b1;
        else if (dsc.act == ACT_XFER) begin
          xaddr_d = dsc.addr;  rem_d = xlen;  st_d = S_DATA;
        end else begin
          if (dsc.act == ACT_SET && mode_q == DMA_A1) len1_d = dsc.len;
          finish = 1'b1;
        end
      end
      S_DATA: begin
        mem_req = 1'b1;  mem_we = dir_q;  mem_addr = xaddr_q;
        if (mem_ack) begin
          if (mem_err) fail = 1'b1;
          else begin
            beat_ok = 1'b1;
            xaddr_d = xaddr_q + ADDR_W'(STEP);
            rem_d   = rem_q - LEN_W'(STEP);
            if (rem_q == LEN_W'(STEP)) finish = 1'b1;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (finish) begin
      ptr_d  = (dsc.act == ACT_LINK) ? dsc.addr : ptr_q + ADDR_W'(stride);
      widx_d = '0;
      if (dsc.last) begin st_d = S_IDLE; cmpl_d = 1'b1; end
      else          st_d = S_FETCH;
    end
    if (fail) begin
      st_d = S_IDLE;
      if (adma_err_en) begin aerr_d = 1'b1; esum_d = 1'b1; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  mode_q <= DMA_NONE;  dir_q <= 1'b0;
      ptr_q <= '0;  xaddr_q <= '0;  rem_q <= '0;  len1_q <= '0;  widx_q <= '0;
      cmpl_q <= 1'b0;  aerr_q <= 1'b0;  esum_q <= 1'b0;
    end else begin
      st_q <= st_d;  mode_q <= mode_d;  dir_q <= dir_d;
      ptr_q <= ptr_d;  xaddr_q <= xaddr_d;  rem_q <= rem_d;  len1_q <= len1_d;  widx_q <= widx_d;
      cmpl_q <= cmpl_d;  aerr_q <= aerr_d;  esum_q <= esum_d;
    end
  end

  assign mem_wdata     = card_rd_data;
  assign card_rd_pop   = beat_ok && dir_q;
  assign card_wr_valid = beat_ok && !dir_q;
  assign card_wr_data  = mem_rdata;
  assign busy          = (st_q != S_IDLE);
  assign desc_ptr      = ptr_q;
  assign xfer_cmpl     = cmpl_q;
  assign adma_err      = aerr_q;
  assign err_summary   = esum_q;
  assign irq           = esum_q | cmpl_q;
endmodule

// File: rtl/adma_engine_chk.sv
module adma_engine_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             blk_cnt_en,
  input logic [CNT_W-1:0] blk_cnt,
  input logic             adma_err_en,
  input logic             mem_req,
  input logic             mem_we,
  input logic [63:0]      mem_addr,
  input logic             mem_ack,
  input logic             mem_err,
  input logic             card_rd_pop,
  input logic             card_wr_valid,
  input logic             card_blk_end,
  input logic             busy,
  input logic [63:0]      desc_ptr,
  input logic             xfer_cmpl,
  input logic             adma_err
);
  // R14
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> $stable(desc_ptr) && !busy);

  // R10
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adma_err) |-> $past(adma_err_en));

  // R13
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && blk_cnt_en && (blk_cnt == '0) |=> !busy && !mem_req);

  // R12
  cmpl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_cmpl) |-> !busy);

  // R8
  blk_end_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_blk_end |-> (card_wr_valid || card_rd_pop));

  // R7
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_wr_valid, card_rd_pop}));

  // R2
  exec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req |=> !busy || mem_req);
endmodule

bind adma_engine adma_engine_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/adma_engine_bench.sv
module adma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  dma_mode = 2'b00;
  logic [63:0] desc_base = '0;
  logic [15:0] blk_size = '0;
  logic [15:0] blk_cnt = 16'd5;
  logic        blk_cnt_en = 1'b1;
  logic        dir_to_mem = 1'b0;
  logic        adma_err_en = 1'b0;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] card_rd_data;
  logic        card_rd_pop, card_wr_valid, card_blk_end;
  logic [31:0] card_wr_data;
  logic        busy, xfer_cmpl, adma_err, err_summary, irq;
  logic [63:0] desc_ptr;

  always #5 clk = ~clk;

  adma_engine u_adma_engine (.*);

  typedef struct { logic [63:0] a; bit we; logic [31:0] d; bit be; bit er; } beat_t;
  beat_t exp_q[$];
  logic [31:0] mem [logic [63:0]];
  int nchk = 0, nfail = 0, cidx = 0, cycn = 0;
  bit err_on = 0, stall = 0, done_flag = 0;
  logic [63:0] err_a = '0, exp_ptr;
  bit exp_cmpl, exp_err;

  assign card_rd_data = 32'hCA000000 + 32'(cidx);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memrd(logic [63:0] a);
    return mem.exists(a) ? mem[a] : (a[31:0] ^ 32'h5EED0000);
  endfunction

  function automatic bit hit(logic [63:0] a);
    return err_on && (a == err_a);
  endfunction

  task automatic put(logic [63:0] a, logic [31:0] w); mem[a] = w; endtask
  task automatic d32(logic [63:0] a, logic [7:0] at, logic [15:0] ln, logic [31:0] ad);
    put(a, {ln, 10'h0, at[5:0]}); put(a + 4, ad);
  endtask
  task automatic d64(logic [63:0] a, logic [7:0] at, logic [15:0] ln, logic [63:0] ad);
    put(a, {ln, 8'h0, at}); put(a + 4, ad[31:0]); put(a + 8, ad[63:32]);
  endtask
  task automatic d1a(logic [63:0] a, logic [6:0] at, logic [19:0] ad);
    put(a, {ad, 5'h0, at});
  endtask
  task automatic d1s(logic [63:0] a, logic [15:0] ln);
    put(a, {ln, 9'h0, 7'h11});
  endtask

  // behavioural reference: expected access stream and final outcome
  task automatic model(int mode, logic [63:0] base, bit dir, int bsz, bit en);
    logic [63:0] p; logic [15:0] len1; int pos, k, eff; bit fin, fault;
    p = base; len1 = 0; pos = 0; k = 0; fin = 0; fault = 0; eff = bsz % 4096;
    exp_q.delete(); exp_cmpl = 0;
    while (!fin && !fault) begin
      int nw; logic [31:0] w [3]; logic [63:0] da; logic [1:0] act; logic [15:0] l16; int len;
      nw = (mode == 1) ? 1 : (mode == 2) ? 2 : 3;
      w = '{32'h0, 32'h0, 32'h0};
      for (int i = 0; i < nw; i++) begin
        logic [63:0] a;
        a = p + 64'(4 * i);
        w[i] = memrd(a);
        exp_q.push_back('{a, 1'b0, w[i], 1'b0, hit(a)});
        if (hit(a)) begin fault = 1; break; end
      end
      if (fault) break;
      if (!w[0][0]) begin fault = 1; break; end
      act = w[0][5:4];
      da = (mode == 1) ? {32'h0, w[0][31:12], 12'h0} : (mode == 2) ? {32'h0, w[1]} : {w[2], w[1]};
      if (act == 2'b10) begin
        l16 = (mode == 1) ? len1 : w[0][31:16];
        len = (l16 == 0) ? 65536 : int'(l16);
        for (int j = 0; j < len / 4; j++) begin
          logic [63:0] a; bit h, be;
          a = da + 64'(4 * j); h = hit(a); be = 0;
          if (!h) begin
            pos += 4;
            if (eff != 0 && pos >= eff) begin be = 1; pos = 0; end
          end
          exp_q.push_back('{a, dir, dir ? 32'hCA000000 + 32'(k) : memrd(a), be, h});
          if (h) begin fault = 1; break; end
          if (dir) k++;
        end
        if (fault) break;
      end else if (act == 2'b01 && mode == 1) len1 = w[0][31:16];
      p = (act == 2'b11) ? da : p + 64'(4 * nw);
      if (w[0][1]) begin exp_cmpl = 1; fin = 1; end
    end
    exp_ptr = p; exp_err = fault && en;
  endtask

  // memory and card responder, checks every accepted access against the queue
  initial begin
    bit pop_seen, held; logic [63:0] held_a;
    pop_seen = 0; held = 0; held_a = '0;
    forever begin
      @(negedge clk);
      if (pop_seen) cidx++;
      cycn++;
      if (mem_req && !(stall && (cycn % 3 == 0))) begin
        mem_ack = 1; mem_err = hit(mem_addr);
        mem_rdata = mem_we ? 32'h0 : memrd(mem_addr);
      end else begin
        mem_ack = 0; mem_err = 0;
      end
      #1;
      if (held) chk(mem_req && mem_addr == held_a, "R14 held address", mem_addr, held_a);
      held = mem_req && !mem_ack; held_a = mem_addr;
      if (mem_ack) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected access", mem_addr, 0);
        else begin
          beat_t e;
          e = exp_q.pop_front();
          chk(mem_addr == e.a, "R6 access address", mem_addr, e.a);
          chk(mem_we == e.we, "R7 access direction", 64'(mem_we), 64'(e.we));
          if (e.we && !e.er) chk(mem_wdata == e.d, "R7 memory write data", 64'(mem_wdata), 64'(e.d));
          if (e.er) chk(!card_wr_valid && !card_rd_pop, "R9 card event on failed access", 64'({card_wr_valid, card_rd_pop}), 0);
          else if (e.we) chk(card_rd_pop, "R7 card pop", 64'(card_rd_pop), 1);
          else if (e.a != 0 && card_wr_valid) chk(card_wr_data == e.d, "R7 card write data", 64'(card_wr_data), 64'(e.d));
          chk(card_blk_end == e.be, "R8 block end flag", 64'(card_blk_end), 64'(e.be));
        end
      end
      pop_seen = card_rd_pop;
    end
  end

  task automatic run(string tag, int mode, logic [63:0] base, bit dir, int bsz, bit en, bit eon, logic [63:0] ea, bit stl);
    @(negedge clk);
    dma_mode = 2'(mode); desc_base = base; dir_to_mem = dir; blk_size = 16'(bsz);
    adma_err_en = en; err_on = eon; err_a = ea; stall = stl; cidx = 0;
    blk_cnt_en = 1; blk_cnt = 16'd3;
    model(mode, base, dir, bsz, en);
    start = 1;
    @(negedge clk);
    start = 0;
    do begin @(negedge clk); #3; end while (busy);
    chk(exp_q.size() == 0, {tag, " accesses left"}, 64'(exp_q.size()), 0);
    chk(desc_ptr == exp_ptr, {tag, " pointer"}, desc_ptr, exp_ptr);
    chk(xfer_cmpl == exp_cmpl, "R12 transfer complete", 64'(xfer_cmpl), 64'(exp_cmpl));
    chk(adma_err == exp_err, "R10 error flag", 64'(adma_err), 64'(exp_err));
    chk(err_summary == exp_err, "R10 error summary", 64'(err_summary), 64'(exp_err));
    chk(irq == (exp_err | exp_cmpl), "R10 irq", 64'(irq), 64'(exp_err | exp_cmpl));
  endtask

  task automatic blocked(string tag, logic [1:0] md, bit cen, logic [15:0] cnt);
    logic [63:0] p0; bit c0;
    @(negedge clk);
    p0 = desc_ptr; c0 = xfer_cmpl; exp_q.delete();
    dma_mode = md; desc_base = 64'h1000; blk_cnt_en = cen; blk_cnt = cnt; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 4; i++) begin
      #3;
      chk(!busy && !mem_req, {tag, " stayed idle"}, 64'({busy, mem_req}), 0);
      @(negedge clk);
    end
    chk(desc_ptr == p0 && xfer_cmpl == c0, {tag, " state unchanged"}, desc_ptr, p0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    chk(!busy && !mem_req && !xfer_cmpl && !adma_err && !err_summary && !irq, "R1 reset state",
        64'({busy, mem_req, xfer_cmpl, adma_err, err_summary, irq}), 0);
    rst_n = 1;

    // two-word 32-bit form, card to memory, stalled memory
    d32(64'h1000, 8'h01, 16'd0, 32'h0);
    d32(64'h1008, 8'h21, 16'd16, 32'h8000);
    d32(64'h1010, 8'h23, 16'd24, 32'h8100);
    run("R2", 2, 64'h1000, 1, 8, 1, 0, 0, 1);

    // link, memory to card, block size upper bits ignored
    d32(64'h1100, 8'h31, 16'd0, 32'h2000);
    d32(64'h2000, 8'h23, 16'd12, 32'h9000);
    run("R5", 2, 64'h1100, 0, 16'h1004, 1, 0, 0, 0);

    // one-word form with length load and link
    d1s(64'h3000, 16'd8);
    d1a(64'h3004, 7'h21, 20'h0000A);
    d1a(64'h3008, 7'h31, 20'h00004);
    d1a(64'h4000, 7'h23, 20'h0000B);
    run("R3", 1, 64'h3000, 0, 12, 1, 0, 0, 1);

    // 64-bit form, attribute bits 7:6 set
    d64(64'h5000, 8'hC1, 16'd0, 64'h0);
    d64(64'h500C, 8'hE3, 16'd8, 64'h1_0000_9000);
    run("R4", 3, 64'h5000, 1, 512, 1, 0, 0, 0);

    // data error with enable set, then clear
    d32(64'h6000, 8'h23, 16'd16, 32'hC000);
    run("R9", 2, 64'h6000, 0, 8, 1, 1, 64'hC008, 0);
    run("R10", 2, 64'h6000, 1, 8, 0, 1, 64'hC008, 0);

    // invalid descriptor
    d32(64'h6100, 8'h21, 16'd8, 32'hC100);
    d32(64'h6108, 8'h20, 16'd8, 32'hC200);
    run("R11", 2, 64'h6100, 0, 8, 1, 0, 0, 0);

    // fetch error on second word of a 64-bit descriptor
    d64(64'h6200, 8'h01, 16'd0, 64'h0);
    d64(64'h620C, 8'h23, 16'd4, 64'hC300);
    run("R9", 3, 64'h6200, 0, 8, 1, 1, 64'h6210, 1);

    // ignored starts
    blocked("R13 count zero", 2'b10, 1, 16'd0);
    blocked("R13 mode none", 2'b00, 0, 16'd3);

    // zero block size: no block ends
    d32(64'h7100, 8'h23, 16'd8, 32'hD000);
    run("R8", 2, 64'h7100, 1, 16'h1000, 1, 0, 0, 0);

    // zero length moves 65536 bytes
    d32(64'h7000, 8'h23, 16'd0, 32'h100000);
    run("R6", 2, 64'h7000, 0, 512, 1, 0, 0, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule